// File: doc/BRIEF.md
# Half-Duplex Carrier Deferral and Collision Backoff Controller

This block sits between a transmit queue and a half-duplex framer and decides the cycle in which a waiting frame may go onto the wire. It watches carrier sense and collision, counts in bit times using a one-cycle `bit_tick` strobe, and gives the framer a single-cycle `tx_start` pulse. The interframe gap has two phases. The first phase qualifies the line: carrier has to stay quiet for 60 bit times, and any carrier seen in this phase restarts the count. The second phase is a fixed 36 bit times during which carrier is ignored. The gap therefore ends 96 bit times after carrier last dropped. The gap is also enforced after the block's own frame ends.

When the framer reports a collision, the block pulses `tx_abort`. The framer sends its jam and stops, while the block counts 32 bit times for the jam. It then waits a random number of 512-bit slots. A free-running LFSR supplies that number, which is drawn from 0 to 2^k − 1, where k is the collision count capped at 10. When the wait ends, the block pulses `tx_retry` and defers again before restarting. If the collision count goes past the programmed limit, the frame is dropped and `excess_col` is pulsed instead.

Top module: `carrier_backoff_ctl`

## Requirements
- R1: During and right after synchronous reset all four outputs are low, and the line counts as having been idle for the full gap.
- R2: When `frame_ready` rises while the gap is already complete and `crs` is low, `tx_start` is high for exactly one cycle, starting the cycle after `frame_ready` is sampled.
- R3: When carrier falls while a frame waits and `bit_tick` is high every cycle, `tx_start` rises 97 clock edges after the first edge that samples `crs` low (96 bit times plus one register stage). `tx_start` is never issued while `crs` is high.
- R4: Carrier seen during the first 60 quiet bit times restarts the qualification, so the start is timed from the later fall.
- R5: Carrier seen during the last 36 bit times of the gap has no effect on when the frame starts.
- R6: After `tx_done` ends the block's own frame, a waiting frame starts 98 edges after the edge that samples `tx_done` is driven, because the full 96-bit gap is counted again.
- R7: `col` sampled during a frame gives a one-cycle `tx_abort` on the next cycle. `col` outside a frame produces no output.
- R8: After the n-th collision of a frame, `tx_retry` comes JAM+1+s·SLOT edges after `tx_abort`, with s between 0 and 2^min(n,10) − 1. A new `tx_start` then follows once the gap is open.
- R9: When the collision count exceeds `retry_limit`, `excess_col` pulses JAM edges after `tx_abort` and no retry follows. The frame is dropped, and the next frame starts again at collision count zero.
- R10: If `col` and `tx_done` are sampled in the same cycle, the collision takes priority and `tx_abort` follows.
- R11: Gap timing advances only on cycles where `bit_tick` is high: exactly 96 ticks are sampled before the edge that raises `tx_start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_tick | input | 1 | One-cycle strobe per bit time |
| frame_ready | input | 1 | A new frame is queued |
| crs | input | 1 | Carrier sense |
| col | input | 1 | Collision detected |
| tx_done | input | 1 | Framer finished the frame cleanly |
| retry_limit | input | ATT_W | Largest number of collisions allowed before the frame is dropped |
| tx_start | output | 1 | Start pulse to the framer |
| tx_abort | output | 1 | Collision pulse; the framer jams and stops |
| tx_retry | output | 1 | Backoff finished; a retry follows |
| excess_col | output | 1 | Frame dropped after too many collisions |

## Verification
Two events can arrive in the same cycle: a collision, and the framer reporting that the frame is complete. The bench drives `col` and `tx_done` together on the first attempt of the backoff sweep and expects `tx_abort` on the next cycle, followed by a retry instead of a return to idle. A second overlap is carrier rising inside the fixed 36-bit phase exactly as the gap would close. The bench checks this by timing the start against the first carrier fall.

// File: rtl/cdb_pkg.sv
package cdb_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_TX,
        ST_JAM,
        ST_BACKOFF,
        ST_DEFER
    } ctl_state_t;

    localparam int unsigned LFSR_W = 16;

    // low k bits set
    function automatic logic [LFSR_W-1:0] slot_mask(input logic [4:0] k);
        return (LFSR_W'(1) << k) - LFSR_W'(1);
    endfunction

    // x^16 + x^14 + x^13 + x^11 + 1, shift left
    function automatic logic [LFSR_W-1:0] lfsr_next(input logic [LFSR_W-1:0] s);
        return {s[LFSR_W-2:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
    endfunction

endpackage

// File: rtl/cdb_gap_timer.sv
module cdb_gap_timer #(
    parameter int unsigned QUAL_BITS = 60,
    parameter int unsigned FIX_BITS  = 36
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic crs,
    input  logic hold,
    output logic gap_open
);
    localparam int unsigned TOTAL = QUAL_BITS + FIX_BITS;
    localparam int unsigned CW    = $clog2(TOTAL + 1);

    logic [CW-1:0] cnt;
    logic          in_qual;
    logic          in_fix;

    assign in_qual  = cnt < CW'(QUAL_BITS);
    assign in_fix   = !in_qual && (cnt < CW'(TOTAL));
    assign gap_open = cnt == CW'(TOTAL);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= CW'(TOTAL);
        end else if (hold) begin
            cnt <= '0;
        end else if (crs && !in_fix) begin
            cnt <= '0;
        end else if (tick && !gap_open) begin
            cnt <= cnt + CW'(1);
        end
    end

    assert_open_on_tick_R11: assert property (@(posedge clk) disable iff (rst)
        $rose(gap_open) |-> $past(tick));

    assert_fix_ignores_crs_R5: assert property (@(posedge clk) disable iff (rst)
        (in_fix && !hold) |=> (cnt >= $past(cnt)));

    assert_qual_restart_R4: assert property (@(posedge clk) disable iff (rst)
        (crs && in_qual && !hold && $past(gap_open)) |=> !gap_open);

endmodule

// File: rtl/cdb_backoff_gen.sv
module cdb_backoff_gen
    import cdb_pkg::*;
#(
    parameter int unsigned SLOT_BITS   = 512,
    parameter int unsigned BACKOFF_CAP = 10,
    parameter logic [15:0] LFSR_SEED   = 16'hACE1
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick,
    input  logic       load,
    input  logic [4:0] exp_k,
    output logic       done
);
    localparam int unsigned BW = $clog2(SLOT_BITS);

    logic [LFSR_W-1:0]      lfsr;
    logic [BACKOFF_CAP-1:0] slots;
    logic [BACKOFF_CAP-1:0] mask_c;
    logic [BW-1:0]          bitc;

    assign mask_c = BACKOFF_CAP'(slot_mask(exp_k));
    assign done   = slots == '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            lfsr <= LFSR_SEED;
        end else begin
            lfsr <= lfsr_next(lfsr);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            slots <= '0;
            bitc  <= '0;
        end else if (load) begin
            slots <= lfsr[BACKOFF_CAP-1:0] & mask_c;
            bitc  <= '0;
        end else if (tick && !done) begin
            if (bitc == BW'(SLOT_BITS - 1)) begin
                bitc  <= '0;
                slots <= slots - BACKOFF_CAP'(1);
            end else begin
                bitc <= bitc + BW'(1);
            end
        end
    end

    assert_slots_in_range_R8: assert property (@(posedge clk) disable iff (rst)
        load |=> (slots <= $past(mask_c)));

    assert_lfsr_alive_R8: assert property (@(posedge clk) disable iff (rst)
        lfsr != '0);

endmodule

// File: rtl/carrier_backoff_ctl.sv
module carrier_backoff_ctl
    import cdb_pkg::*;
#(
    parameter int unsigned QUAL_BITS   = 60,
    parameter int unsigned FIX_BITS    = 36,
    parameter int unsigned JAM_BITS    = 32,
    parameter int unsigned SLOT_BITS   = 512,
    parameter int unsigned BACKOFF_CAP = 10,
    parameter int unsigned ATT_W       = 4,
    parameter logic [15:0] LFSR_SEED   = 16'hACE1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             bit_tick,
    input  logic             frame_ready,
    input  logic             crs,
    input  logic             col,
    input  logic             tx_done,
    input  logic [ATT_W-1:0] retry_limit,
    output logic             tx_start,
    output logic             tx_abort,
    output logic             tx_retry,
    output logic             excess_col
);
    localparam int unsigned JW = $clog2(JAM_BITS);

    ctl_state_t       state;
    logic [ATT_W:0]   attempts;
    logic [JW-1:0]    jcnt;
    logic             gap_open;
    logic             hold_gap;
    logic             jam_last;
    logic             over;
    logic             bo_load;
    logic             bo_done;
    logic [4:0]       bo_exp;
    logic             may_go;

    assign hold_gap = (state == ST_TX) || (state == ST_JAM);
    assign jam_last = bit_tick && (jcnt == JW'(JAM_BITS - 1));
    assign over     = attempts > {1'b0, retry_limit};
    assign bo_load  = (state == ST_JAM) && jam_last && !over;
    assign may_go   = gap_open && !crs;

    always_comb begin
        if (int'(attempts) > int'(BACKOFF_CAP)) begin
            bo_exp = 5'(BACKOFF_CAP);
        end else begin
            bo_exp = 5'(attempts);
        end
    end

    cdb_gap_timer #(
        .QUAL_BITS (QUAL_BITS),
        .FIX_BITS  (FIX_BITS)
    ) gap_i (
        .clk      (clk),
        .rst      (rst),
        .tick     (bit_tick),
        .crs      (crs),
        .hold     (hold_gap),
        .gap_open (gap_open)
    );

    cdb_backoff_gen #(
        .SLOT_BITS   (SLOT_BITS),
        .BACKOFF_CAP (BACKOFF_CAP),
        .LFSR_SEED   (LFSR_SEED)
    ) bo_i (
        .clk   (clk),
        .rst   (rst),
        .tick  (bit_tick),
        .load  (bo_load),
        .exp_k (bo_exp),
        .done  (bo_done)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_IDLE;
            attempts   <= '0;
            jcnt       <= '0;
            tx_start   <= 1'b0;
            tx_abort   <= 1'b0;
            tx_retry   <= 1'b0;
            excess_col <= 1'b0;
        end else begin
            tx_start   <= 1'b0;
            tx_abort   <= 1'b0;
            tx_retry   <= 1'b0;
            excess_col <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (frame_ready && may_go) begin
                        tx_start <= 1'b1;
                        state    <= ST_TX;
                    end
                end
                ST_DEFER: begin
                    if (may_go) begin
                        tx_start <= 1'b1;
                        state    <= ST_TX;
                    end
                end
                ST_TX: begin
                    if (col) begin
                        tx_abort <= 1'b1;
                        attempts <= attempts + (ATT_W+1)'(1);
                        jcnt     <= '0;
                        state    <= ST_JAM;
                    end else if (tx_done) begin
                        attempts <= '0;
                        state    <= ST_IDLE;
                    end
                end
                ST_JAM: begin
                    if (jam_last) begin
                        if (over) begin
                            excess_col <= 1'b1;
                            attempts   <= '0;
                            state      <= ST_IDLE;
                        end else begin
                            state <= ST_BACKOFF;
                        end
                    end else if (bit_tick) begin
                        jcnt <= jcnt + JW'(1);
                    end
                end
                ST_BACKOFF: begin
                    if (bo_done) begin
                        tx_retry <= 1'b1;
                        state    <= ST_DEFER;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assert_start_needs_gap_R3: assert property (@(posedge clk) disable iff (rst)
        tx_start |-> $past(gap_open && !crs));

    assert_abort_after_col_R7: assert property (@(posedge clk) disable iff (rst)
        tx_abort |-> $past(col));

    assert_retry_after_wait_R8: assert property (@(posedge clk) disable iff (rst)
        tx_retry |-> $past(bo_done));

    assert_excess_exclusive_R9: assert property (@(posedge clk) disable iff (rst)
        excess_col |-> (!tx_retry && !tx_start && !tx_abort));

    assert_start_single_R2: assert property (@(posedge clk) disable iff (rst)
        tx_start |=> !tx_start);

endmodule

// File: tb/carrier_backoff_ctl_tb_top.sv
`timescale 1ns/1ps
module carrier_backoff_ctl_tb_top;
    localparam int QUAL = 60;
    localparam int FIX  = 36;
    localparam int JAM  = 32;
    localparam int SLOT = 4;
    localparam int CAP  = 10;
    localparam int AW   = 4;
    localparam int GAP  = QUAL + FIX;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic bit_tick = 1'b1;
    logic frame_ready = 1'b0;
    logic crs = 1'b0;
    logic col = 1'b0;
    logic tx_done = 1'b0;
    logic [AW-1:0] retry_limit = 4'd12;
    logic tx_start, tx_abort, tx_retry, excess_col;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    carrier_backoff_ctl #(
        .QUAL_BITS(QUAL), .FIX_BITS(FIX), .JAM_BITS(JAM), .SLOT_BITS(SLOT),
        .BACKOFF_CAP(CAP), .ATT_W(AW), .LFSR_SEED(16'hACE1)
    ) dut_i (
        .clk(clk), .rst(rst), .bit_tick(bit_tick), .frame_ready(frame_ready),
        .crs(crs), .col(col), .tx_done(tx_done), .retry_limit(retry_limit),
        .tx_start(tx_start), .tx_abort(tx_abort), .tx_retry(tx_retry),
        .excess_col(excess_col)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic wait_pulse(input int sel, input int limit, output int e);
        e = 0;
        for (int i = 0; i < limit; i++) begin
            step();
            e++;
            if ((sel == 0 && tx_start) || (sel == 1 && tx_abort) ||
                (sel == 2 && tx_retry) || (sel == 3 && excess_col)) return;
        end
        e = -1;
    endtask

    task automatic end_frame();
        tx_done = 1'b1;
        step();
        tx_done = 1'b0;
    endtask

    initial begin
        int e;
        int e2;
        int s;
        int ticks;
        bit seen;
        for (int i = 0; i < 3; i++) step();
        rst = 1'b0;
        step();
        // R1: quiet after reset
        chk(!tx_start && !tx_abort && !tx_retry && !excess_col, "R1 outputs", 
            int'({tx_start, tx_abort, tx_retry, excess_col}), 0);

        // R2: idle line, immediate start
        frame_ready = 1'b1;
        wait_pulse(0, 10, e);
        chk(e == 1, "R2 idle start latency", e, 1);
        frame_ready = 1'b0;
        end_frame();
        chk(!tx_start, "R2 start is one cycle", int'(tx_start), 0);

        // R3: busy line, start 96 bit times after carrier falls
        crs = 1'b1;
        frame_ready = 1'b1;
        seen = 0;
        for (int i = 0; i < 5; i++) begin step(); if (tx_start) seen = 1; end
        chk(!seen, "R3 no start while carrier", int'(seen), 0);
        crs = 1'b0;
        wait_pulse(0, 300, e);
        chk(e == GAP + 1, "R3 deferral", e, GAP + 1);

        // R6: gap after own frame
        tx_done = 1'b1;
        step();
        tx_done = 1'b0;
        wait_pulse(0, 300, e2);
        chk(e2 + 1 == GAP + 2, "R6 gap after own frame", e2 + 1, GAP + 2);

        // R4: carrier inside qualification restarts
        end_frame();
        crs = 1'b1;
        for (int i = 0; i < 3; i++) step();
        crs = 1'b0;
        for (int i = 0; i < 30; i++) step();
        crs = 1'b1;
        step();
        crs = 1'b0;
        wait_pulse(0, 300, e);
        chk(e == GAP + 1, "R4 restart on early carrier", e, GAP + 1);

        // R5: carrier inside fixed phase ignored
        end_frame();
        crs = 1'b1;
        for (int i = 0; i < 3; i++) step();
        crs = 1'b0;
        seen = 0;
        for (int i = 0; i < 70; i++) begin step(); if (tx_start) seen = 1; end
        crs = 1'b1;
        for (int i = 0; i < 3; i++) begin step(); if (tx_start) seen = 1; end
        crs = 1'b0;
        wait_pulse(0, 300, e);
        chk(!seen && (73 + e == GAP + 1), "R5 late carrier ignored", 73 + e, GAP + 1);

        // R11: sparse bit ticks
        end_frame();
        crs = 1'b1;
        for (int i = 0; i < 3; i++) step();
        crs = 1'b0;
        ticks = 0;
        e = -1;
        for (int i = 0; i < 600; i++) begin
            bit_tick = (i % 3) == 0;
            step();
            if (tx_start) begin e = ticks; break; end
            ticks += int'(bit_tick);
        end
        bit_tick = 1'b1;
        chk(e == GAP, "R11 ticks before start", e, GAP);

        // R7: collision outside a frame ignored
        end_frame();
        frame_ready = 1'b0;
        col = 1'b1;
        step();
        col = 1'b0;
        seen = 0;
        for (int i = 0; i < 4; i++) begin
            step();
            if (tx_abort || tx_retry || excess_col || tx_start) seen = 1;
        end
        chk(!seen, "R7 idle collision ignored", int'(seen), 0);

        // R8 / R10: backoff sweep with collision each attempt
        retry_limit = 4'd12;
        frame_ready = 1'b1;
        wait_pulse(0, 300, e);
        chk(e > 0, "R8 first start", e, 1);
        frame_ready = 1'b0;
        for (int n = 1; n <= 12; n++) begin
            step();
            col = 1'b1;
            if (n == 1) tx_done = 1'b1;  // R10 overlap
            step();
            col = 1'b0;
            tx_done = 1'b0;
            if (n == 1) chk(tx_abort == 1'b1, "R10 collision wins over done", int'(tx_abort), 1);
            else chk(tx_abort == 1'b1, "R7 abort after collision", int'(tx_abort), 1);
            wait_pulse(2, 10000, e);
            s = (e - JAM - 1) / SLOT;
            chk(e > JAM && ((e - JAM - 1) % SLOT == 0) &&
                s <= (1 << ((n > CAP) ? CAP : n)) - 1,
                "R8 backoff window", e, JAM + 1);
            wait_pulse(0, 300, e2);
            chk(e2 > 0, "R8 restart after retry", e2, 1);
        end

        // R9: thirteenth collision exceeds limit
        step();
        col = 1'b1;
        step();
        col = 1'b0;
        chk(tx_abort == 1'b1, "R9 abort on final collision", int'(tx_abort), 1);
        wait_pulse(3, 200, e);
        chk(e == JAM, "R9 excess timing", e, JAM);
        seen = 0;
        for (int i = 0; i < 150; i++) begin
            step();
            if (tx_retry || tx_start) seen = 1;
        end
        chk(!seen, "R9 frame dropped", int'(seen), 0);
        frame_ready = 1'b1;
        wait_pulse(0, 10, e);
        chk(e == 1, "R9 next frame starts", e, 1);
        frame_ready = 1'b0;
        step();
        col = 1'b1;
        step();
        col = 1'b0;
        wait_pulse(2, 200, e);
        chk(e > 0 && e <= JAM + 1 + SLOT, "R9 count reset", e, JAM + 1 + SLOT);

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(150000 * 5);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule